// File: doc/BRIEF.md
# YUV 4:2:2 Overlay Alpha Blender

This block mixes a main video stream with a graphics overlay stream. Both are packed YUV 4:2:2 and move one pixel pair per 32-bit word. Each word carries the bytes U0, Y0, V0 and Y1. Each overlay pixel picks one of two programmable 8-bit weights through a select bit that rides in the least significant bit of an overlay chroma byte. Pixel 0 uses the LSB of U0 and pixel 1 uses the LSB of V0.

The pixel-0 weight blends U0, Y0 and V0. The pixel-1 weight blends only Y1. The overlay chroma bytes take part in the arithmetic with their LSB cleared. When overlay is switched off, the main words pass through unchanged.

A small write-only configuration port loads the enable bit and the two weights. Pixel words enter and leave on valid/ready handshakes. In between, they cross a two-slot pipeline. Each slot is a two-state machine with the states SLOT_EMPTY and SLOT_FULL. The transitions are:

- **FILL**: an empty slot takes data.
- **PASS**: a full slot hands its data forward and refills in the same cycle.
- **DRAIN**: a full slot hands its data forward and empties.
- **HOLD**: a full slot keeps its data because the slot after it cannot accept.

Top module: `ovb_top`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, overlay is disabled and both weights are 0.
- R2: A write with cfg_wr=1 takes effect at that clock edge. Address 0 loads the enable from bit 0, address 1 loads the select-0 weight, and address 2 loads the select-1 weight. A write to address 3 changes nothing.
- R3: A word holds U0 in bits 7:0, Y0 in bits 15:8, V0 in bits 23:16 and Y1 in bits 31:24. This applies to in_main, in_ovl and out_word alike.
- R4: With overlay disabled, out_word equals the in_main word that was accepted.
- R5: With overlay enabled, each output byte is (a*o + (256-a)*m + 128) >> 8, limited to 255. Here a is the weight, o is the overlay byte and m is the main byte.
- R6: The weight for U0, Y0 and V0 depends on bit 0 of in_ovl. A value of 0 selects the select-0 weight and a value of 1 selects the select-1 weight.
- R7: The weight for Y1 depends on bit 16 of in_ovl, with the same encoding as R6.
- R8: The overlay U0 and V0 bytes enter the arithmetic with their bit 0 forced to 0. The overlay Y0 and Y1 bytes are used whole.
- R9: A word accepted at clock edge t shows on out_valid/out_word after edge t+1 if out_ready is 1. One word per cycle is sustained.
- R10: While out_valid=1 and out_ready=0, out_valid and out_word stay unchanged. Every word leaves exactly once, in order.
- R11: in_ready is 1 unless both slots are full and out_ready is 0.
- R12: Enable and weights are sampled when the word is accepted. A later configuration write does not alter a word already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_main | input | 32 | Main image pixel pair |
| in_ovl | input | 32 | Overlay image pixel pair |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can take the output word |
| out_word | output | 32 | Blended pixel pair |

## Verification
The hardest situation to reach from the ports is a configuration change that lands while a word is still inside the pipeline, so that the old and new weights must not mix. A directed step accepts a word and writes a new weight in the very next cycle, before the word has come out.

Random runs also mix configuration writes, including writes to the unused address, with random stalls on both handshakes. Under these conditions the same case arises with the slots full and held.

// File: rtl/ovb_pkg.sv
`timescale 1ns/1ps
package ovb_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

    localparam int CFG_AW = 2;

    localparam logic [CFG_AW-1:0] CFG_CTRL    = 2'd0;
    localparam logic [CFG_AW-1:0] CFG_WEIGHT0 = 2'd1;
    localparam logic [CFG_AW-1:0] CFG_WEIGHT1 = 2'd2;

    localparam int LANES   = 4;
    localparam int LANE_U0 = 0;
    localparam int LANE_Y0 = 1;
    localparam int LANE_V0 = 2;
    localparam int LANE_Y1 = 3;

endpackage

// File: rtl/ovb_cfg_regs.sv
`timescale 1ns/1ps
module ovb_cfg_regs
    import ovb_pkg::*;
#(
    parameter int ALPHA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [ALPHA_W-1:0] cfg_wdata,
    output logic               ovl_en,
    output logic [ALPHA_W-1:0] weight0,
    output logic [ALPHA_W-1:0] weight1
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovl_en  <= 1'b0;
            weight0 <= '0;
            weight1 <= '0;
        end else if (cfg_wr) begin
            unique case (cfg_addr)
                CFG_CTRL:    ovl_en  <= cfg_wdata[0];
                CFG_WEIGHT0: weight0 <= cfg_wdata;
                CFG_WEIGHT1: weight1 <= cfg_wdata;
                default:     ;
            endcase
        end
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == CFG_WEIGHT1) |=> weight1 == $past(cfg_wdata)); // R2

    AST_CFG_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == 2'd3) |=> ($stable(weight0) && $stable(weight1) && $stable(ovl_en))); // R2

endmodule

// File: rtl/ovb_pipe_ctrl.sv
`timescale 1ns/1ps
module ovb_pipe_ctrl
    import ovb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic adv1,
    output logic adv2,
    output logic out_valid
);

    slot_e st1, st1_nx;
    slot_e st2, st2_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1 <= SLOT_EMPTY;
            st2 <= SLOT_EMPTY;
        end else begin
            st1 <= st1_nx;
            st2 <= st2_nx;
        end
    end

    always_comb begin
        adv2   = 1'b0;
        adv1   = 1'b0;
        st1_nx = st1;
        st2_nx = st2;
        unique case (st2)
            SLOT_EMPTY: adv2 = 1'b1;
            SLOT_FULL:  adv2 = out_ready;
        endcase
        unique case (st1)
            SLOT_EMPTY: adv1 = 1'b1;
            SLOT_FULL:  adv1 = adv2;
        endcase
        if (adv2) st2_nx = st1;
        if (adv1) st1_nx = in_valid ? SLOT_FULL : SLOT_EMPTY;
    end

    assign in_ready  = adv1;
    assign out_valid = (st2 == SLOT_FULL);

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid); // R10

    AST_FILL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (st1 == SLOT_FULL)); // R9

endmodule

// File: rtl/ovb_lane.sv
`timescale 1ns/1ps
module ovb_lane #(
    parameter int PIX_W     = 8,
    parameter int ALPHA_W   = 8,
    parameter bit IS_CHROMA = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv1,
    input  logic               adv2,
    input  logic [PIX_W-1:0]   main_b,
    input  logic [PIX_W-1:0]   ovl_b,
    input  logic [ALPHA_W-1:0] alpha,
    output logic [PIX_W-1:0]   res
);

    localparam int SUM_W = PIX_W + ALPHA_W + 1;
    localparam int SCALE = 1 << ALPHA_W;
    localparam int HALF  = 1 << (ALPHA_W - 1);
    localparam logic [PIX_W-1:0] OV_MASK = IS_CHROMA ? ~PIX_W'(1) : '1;

    logic [PIX_W-1:0] ov_eff;
    logic [SUM_W-1:0] a_x, ai_x, ov_x, mn_x, sum_nx;
    logic [SUM_W-1:0] s1_sum;

    assign ov_eff = ovl_b & OV_MASK;

    always_comb begin
        a_x    = SUM_W'(alpha);
        ai_x   = SUM_W'(SCALE) - a_x;
        ov_x   = SUM_W'(ov_eff);
        mn_x   = SUM_W'(main_b);
        sum_nx = a_x * ov_x + ai_x * mn_x + SUM_W'(HALF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_sum <= '0;
        end else if (adv1) begin
            s1_sum <= sum_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
        end else if (adv2) begin
            res <= s1_sum[SUM_W-1] ? '1 : s1_sum[ALPHA_W +: PIX_W];
        end
    end

    AST_ZERO_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv1 && alpha == '0) |=> (s1_sum[ALPHA_W +: PIX_W] == $past(main_b) && !s1_sum[SUM_W-1])); // R4

endmodule

// File: rtl/ovb_top.sv
`timescale 1ns/1ps
module ovb_top
    import ovb_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int ALPHA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [ALPHA_W-1:0]     cfg_wdata,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*PIX_W-1:0] in_main,
    input  logic [LANES*PIX_W-1:0] in_ovl,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LANES*PIX_W-1:0] out_word
);

    localparam int SEL0_BIT = LANE_U0 * PIX_W;
    localparam int SEL1_BIT = LANE_V0 * PIX_W;

    logic               ovl_en;
    logic [ALPHA_W-1:0] weight0, weight1;
    logic [ALPHA_W-1:0] a_pix0, a_pix1;
    logic               adv1, adv2;

    ovb_cfg_regs #(.ALPHA_W(ALPHA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ovl_en    (ovl_en),
        .weight0   (weight0),
        .weight1   (weight1)
    );

    ovb_pipe_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .adv1      (adv1),
        .adv2      (adv2),
        .out_valid (out_valid)
    );

    always_comb begin
        a_pix0 = '0;
        a_pix1 = '0;
        if (ovl_en) begin
            a_pix0 = in_ovl[SEL0_BIT] ? weight1 : weight0;
            a_pix1 = in_ovl[SEL1_BIT] ? weight1 : weight0;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam bit CHROMA = (i == LANE_U0) || (i == LANE_V0);
        ovb_lane #(
            .PIX_W     (PIX_W),
            .ALPHA_W   (ALPHA_W),
            .IS_CHROMA (CHROMA)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv1   (adv1),
            .adv2   (adv2),
            .main_b (in_main[i*PIX_W +: PIX_W]),
            .ovl_b  (in_ovl[i*PIX_W +: PIX_W]),
            .alpha  ((i == LANE_Y1) ? a_pix1 : a_pix0),
            .res    (out_word[i*PIX_W +: PIX_W])
        );
    end

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R10

    AST_READY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R11

endmodule

// File: tb/ovb_top_test.sv
`timescale 1ns/1ps
module ovb_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_main = '0;
    logic [31:0] in_ovl = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    bit         m_en = 1'b0;
    logic [7:0] m_w0 = '0;
    logic [7:0] m_w1 = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    bit          s_ovalid, s_iready, s_fire;
    logic [31:0] s_oword;

    ovb_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_main(in_main), .in_ovl(in_ovl), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] blend(input logic [7:0] a, input logic [7:0] o, input logic [7:0] m);
        int s;
        s = int'(a) * int'(o) + (256 - int'(a)) * int'(m) + 128;
        s = s >> 8;
        if (s > 255) s = 255;
        return 8'(s);
    endfunction

    function automatic logic [31:0] model(input logic [31:0] m, input logic [31:0] o,
                                          input bit en, input logic [7:0] w0, input logic [7:0] w1);
        logic [7:0] p0, p1;
        if (!en) return m;
        p0 = o[0]  ? w1 : w0;
        p1 = o[16] ? w1 : w0;
        return {blend(p1, o[31:24], m[31:24]),
                blend(p0, o[23:16] & 8'hFE, m[23:16]),
                blend(p0, o[15:8], m[15:8]),
                blend(p0, o[7:0] & 8'hFE, m[7:0])};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit iv, input logic [31:0] m, input logic [31:0] o, input bit ordy,
                        input bit cw, input logic [1:0] ca, input logic [7:0] cd, input string tag);
        @(negedge clk);
        in_valid = iv; in_main = m; in_ovl = o; out_ready = ordy;
        cfg_wr = cw; cfg_addr = ca; cfg_wdata = cd;
        #1;
        s_ovalid = out_valid; s_iready = in_ready; s_oword = out_word;
        s_fire = iv && in_ready;
        if (s_fire) begin
            exp_q.push_back(model(m, o, m_en, m_w0, m_w1));
            tag_q.push_back(tag);
        end
        if (out_valid && ordy) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected word", out_word, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(out_word === e, t, out_word, e);
            end
        end
        if (cw) begin
            case (ca)
                2'd0: m_en = cd[0];
                2'd1: m_w0 = cd;
                2'd2: m_w1 = cd;
                default: ;
            endcase
        end
    endtask

    task automatic cfg(input logic [1:0] a, input logic [7:0] d);
        step(1'b0, 32'h0, 32'h0, 1'b1, 1'b1, a, d, "cfg");
    endtask

    task automatic send(input logic [31:0] m, input logic [31:0] o, input string tag);
        step(1'b1, m, o, 1'b1, 1'b0, 2'd0, 8'h0, tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 2'd0, 8'h0, "idle");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        int unused_seed;
        unused_seed = $urandom(32'h5EED1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'h0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'h1);

        // R1: weights cleared -> enabled blend with zero weight returns main
        cfg(2'd0, 8'h01);
        send(32'h11223344, 32'hFFFFFFFF, "R1 zero weights");
        idle(3);

        // R4: disabled passthrough
        cfg(2'd0, 8'h00);
        cfg(2'd1, 8'h80);
        cfg(2'd2, 8'h80);
        for (int k = 0; k < 4; k++) send($urandom, $urandom, "R4 passthrough");
        idle(3);

        // R3 / R5: byte positions and arithmetic
        cfg(2'd0, 8'h01);
        cfg(2'd1, 8'h40);
        cfg(2'd2, 8'hC0);
        send(32'h10305070, 32'hF0D0B090, "R3 byte lanes");
        send(32'h00000000, 32'hFEFEFEFE, "R5 blend");
        send(32'hFFFFFFFF, 32'hFFFFFFFF, "R5 saturate top");
        idle(3);

        // R6 / R7: select bits
        cfg(2'd1, 8'h00);
        cfg(2'd2, 8'hFF);
        send(32'h80808080, 32'h20202021, "R6 pixel0 select one");
        send(32'h80808080, 32'h20202020, "R6 pixel0 select zero");
        send(32'h80808080, 32'h20212020, "R7 pixel1 select one");
        send(32'h40404040, 32'hA0A1A0A0, "R7 pixel1 only Y1");
        idle(3);

        // R8: chroma LSB cleared in arithmetic
        send(32'h00000000, 32'h01FF01FF, "R8 chroma lsb");
        send(32'h00000000, 32'h03FF03FF, "R8 luma whole");
        idle(3);

        // R9: latency and throughput
        send(32'h0A0B0C0D, 32'h00000000, "R9 latency");
        step(1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 2'd0, 8'h0, "idle");
        chk(s_ovalid == 1'b0, "R9 not yet valid", 32'(s_ovalid), 32'h0);
        step(1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 2'd0, 8'h0, "idle");
        chk(s_ovalid == 1'b1, "R9 valid after two edges", 32'(s_ovalid), 32'h1);
        for (int k = 0; k < 6; k++) begin
            send($urandom, $urandom, "R9 back to back");
            chk(s_iready == 1'b1, "R9 throughput ready", 32'(s_iready), 32'h1);
        end
        idle(3);

        // R10 / R11: back-pressure
        step(1'b1, 32'h01010101, 32'h0, 1'b0, 1'b0, 2'd0, 8'h0, "R10 stall a");
        step(1'b1, 32'h02020202, 32'h0, 1'b0, 1'b0, 2'd0, 8'h0, "R10 stall b");
        step(1'b1, 32'h03030303, 32'h0, 1'b0, 1'b0, 2'd0, 8'h0, "R10 stall c");
        chk(s_iready == 1'b0, "R11 full and stalled", 32'(s_iready), 32'h0);
        held = s_oword;
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 2'd0, 8'h0, "idle");
            chk(s_ovalid && s_oword === held, "R10 word held", s_oword, held);
        end
        step(1'b1, 32'h04040404, 32'h0, 1'b1, 1'b0, 2'd0, 8'h0, "R10 refill");
        idle(4);

        // R12: configuration change while word in flight
        cfg(2'd1, 8'h20);
        send(32'h00000000, 32'hFFFEFFFE, "R12 old weight kept");
        cfg(2'd1, 8'hE0);
        idle(3);

        // R2: write to spare address ignored
        cfg(2'd2, 8'hC0);
        cfg(2'd3, 8'h11);
        send(32'h10101010, 32'hF0F1F0F1, "R2 spare address");
        idle(3);

        // R5 random mix with stalls and configuration writes
        for (int k = 0; k < 3000; k++) begin
            bit cw;
            cw = ($urandom % 20) == 0;
            step(($urandom % 10) < 7, $urandom, $urandom, ($urandom % 10) < 7,
                 cw, 2'($urandom), 8'($urandom), "R5 random");
        end
        for (int k = 0; k < 12; k++) idle(1);
        chk(exp_q.size() == 0, "R10 all words delivered", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule